// File: doc/BRIEF.md
# Interrupting General-Purpose Pin Bank

This block is a 32-pin general-purpose I/O bank with a small word-addressed register interface. Each pin is either an output, driven from a data register, or an input. Every pin level is taken through a two-stage synchroniser and can be read back whatever its direction. A pin can also raise an interrupt on one of four trigger conditions.

Each pin has a 2-bit trigger code. Pins 0 to 15 take theirs from the low configuration register and pins 16 to 31 from the high one. When a pin's trigger condition holds, a sticky status bit is set. Software clears a status bit by writing a 1 to it. Masked status from the lower half-bank drives one interrupt request and masked status from the upper half-bank drives a second one. Integrators connect the two requests to separate lines of the interrupt controller.

Top module: `pin_bank_irq`

## Requirements
- R1: After reset the data, direction, both configuration and mask registers read 0, every pin is an input (`pad_oe` = 0), and both interrupt requests are low.
- R2: The word index on `reg_word` selects the register: 0 data, 1 direction, 2 pad level (read only), 3 low configuration, 4 high configuration, 5 mask, 6 status. Writable registers read back what was written. Index 7 reads 0, and writes to index 2 or 7 change no register.
- R3: `pad_oe` equals the direction register and `pad_out` equals the data register. A direction bit of 1 makes the pin an output.
- R4: A read of index 2 returns the pin levels from `pad_in` two clock edges after they change, for input and output pins alike.
- R5: Trigger codes are 0 low level, 1 high level, 2 rising edge and 3 falling edge. Pin n < 16 uses low configuration bits [2n+1:2n]. Pin n ≥ 16 uses high configuration bits [2(n-16)+1:2(n-16)].
- R6: Writing a 1 to a status bit clears it and writing a 0 leaves it unchanged. A status bit set by an edge stays set until it is cleared.
- R7: While a level trigger condition holds, its status bit is set again on every clock, so clearing it has no lasting effect.
- R8: If a trigger sets a status bit in the same cycle that software clears it, the bit ends up set.
- R9: `irq_lo` is the OR over pins 0 to 15 of status AND mask, and `irq_hi` is the same for pins 16 to 31.
- R10: An edge on `pad_in` sets its status bit at the third rising clock edge after the change. The interrupt request follows in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_word | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the index |
| pad_in | input | 32 | Levels seen at the pins |
| pad_out | output | 32 | Output values for the pins |
| pad_oe | output | 32 | Output enable per pin |
| irq_lo | output | 1 | Interrupt request for pins 0–15 |
| irq_hi | output | 1 | Interrupt request for pins 16–31 |

## Verification
Random trigger configurations are paired with a random old pin vector and a random new pin vector. A status clear falls between the two vectors, so each of the four trigger codes gives a different predicted bit for the same pin history. A wrong code decode or a swapped half-bank therefore shows up as a mismatch. Random masks over that status separate the two interrupt outputs. Directed runs cover the following cases:
- edge timing, counted edge by edge
- the effect of clears on level triggers versus sticky edge triggers
- a clear that lands exactly in the cycle an edge sets the bit

// File: rtl/pin_bank_pkg.sv
`timescale 1ns/1ps
package pin_bank_pkg;
  localparam int unsigned PINS = 32;
  localparam int unsigned HALF = PINS / 2;
  localparam int unsigned WORD_W = 3;

  localparam logic [WORD_W-1:0] IDX_DATA   = 3'd0;
  localparam logic [WORD_W-1:0] IDX_DIR    = 3'd1;
  localparam logic [WORD_W-1:0] IDX_PAD    = 3'd2;
  localparam logic [WORD_W-1:0] IDX_CFG_LO = 3'd3;
  localparam logic [WORD_W-1:0] IDX_CFG_HI = 3'd4;
  localparam logic [WORD_W-1:0] IDX_MASK   = 3'd5;
  localparam logic [WORD_W-1:0] IDX_STAT   = 3'd6;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  // Trigger code of one pin from the two configuration words.
  function automatic trig_e pick_trig(input logic [PINS-1:0] cfg_lo,
                                      input logic [PINS-1:0] cfg_hi,
                                      input int unsigned pin);
    int unsigned n;
    logic [1:0] c;
    n = pin % HALF;
    if (pin >= HALF) c = cfg_hi[2*n +: 2];
    else             c = cfg_lo[2*n +: 2];
    return trig_e'(c);
  endfunction

  // Whether a trigger condition holds for the current and previous level.
  function automatic logic trig_fires(input trig_e t, input logic cur, input logic prv);
    logic r;
    unique case (t)
      TRIG_LOW:  r = ~cur;
      TRIG_HIGH: r = cur;
      TRIG_RISE: r = cur & ~prv;
      TRIG_FALL: r = ~cur & prv;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pin_bank_sync.sv
`timescale 1ns/1ps
module pin_bank_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pin_bank_detect.sv
`timescale 1ns/1ps
module pin_bank_detect
  import pin_bank_pkg::*;
#(
  parameter int unsigned W = PINS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] cfg_lo,
  input  logic [W-1:0] cfg_hi,
  output logic [W-1:0] hit
);
  logic [W-1:0] level_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_prev <= '0;
    else        level_prev <= level;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    trig_e code;
    assign code   = pick_trig(cfg_lo, cfg_hi, i);
    assign hit[i] = trig_fires(code, level[i], level_prev[i]);
  end
endmodule

// File: rtl/pin_bank_regs.sv
`timescale 1ns/1ps
module pin_bank_regs
  import pin_bank_pkg::*;
#(
  parameter int unsigned W = PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_word,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      pad_level,
  input  logic [W-1:0]      stat,
  output logic [W-1:0]      bus_rdata,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      cfg_lo_q,
  output logic [W-1:0]      cfg_hi_q,
  output logic [W-1:0]      mask_q,
  output logic [W-1:0]      clr_mask
);
  logic wr_en;
  assign wr_en = bus_sel & bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
    end else if (wr_en) begin
      unique case (bus_word)
        IDX_DATA:   data_q   <= bus_wdata;
        IDX_DIR:    dir_q    <= bus_wdata;
        IDX_CFG_LO: cfg_lo_q <= bus_wdata;
        IDX_CFG_HI: cfg_hi_q <= bus_wdata;
        IDX_MASK:   mask_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign clr_mask = (wr_en && bus_word == IDX_STAT) ? bus_wdata : '0;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      unique case (bus_word)
        IDX_DATA:   bus_rdata = data_q;
        IDX_DIR:    bus_rdata = dir_q;
        IDX_PAD:    bus_rdata = pad_level;
        IDX_CFG_LO: bus_rdata = cfg_lo_q;
        IDX_CFG_HI: bus_rdata = cfg_hi_q;
        IDX_MASK:   bus_rdata = mask_q;
        IDX_STAT:   bus_rdata = stat;
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pin_bank_status.sv
`timescale 1ns/1ps
module pin_bank_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] st_q
);
  // Hardware set has priority over a software clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~clr_mask) | hit;
  end
endmodule

// File: rtl/pin_bank_irq.sv
`timescale 1ns/1ps
module pin_bank_irq
  import pin_bank_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_word,
  input  logic [PINS-1:0]   reg_wdata,
  output logic [PINS-1:0]   reg_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int unsigned NHALVES = PINS / HALF;

  logic [PINS-1:0] pad_level;
  logic [PINS-1:0] trig_hit;
  logic [PINS-1:0] clr_mask;
  logic [PINS-1:0] st_q;
  logic [PINS-1:0] mask_q;
  logic [PINS-1:0] cfg_lo_q;
  logic [PINS-1:0] cfg_hi_q;
  logic [PINS-1:0] pending;
  logic [NHALVES-1:0] half_req;

  pin_bank_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_level)
  );

  pin_bank_regs #(.W(PINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(reg_sel), .bus_wr(reg_wr), .bus_word(reg_word), .bus_wdata(reg_wdata),
    .pad_level(pad_level), .stat(st_q), .bus_rdata(reg_rdata),
    .data_q(pad_out), .dir_q(pad_oe), .cfg_lo_q(cfg_lo_q), .cfg_hi_q(cfg_hi_q),
    .mask_q(mask_q), .clr_mask(clr_mask)
  );

  pin_bank_detect #(.W(PINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .level(pad_level),
    .cfg_lo(cfg_lo_q), .cfg_hi(cfg_hi_q), .hit(trig_hit)
  );

  pin_bank_status #(.W(PINS)) u_status (
    .clk(clk), .rst_n(rst_n), .hit(trig_hit), .clr_mask(clr_mask), .st_q(st_q)
  );

  assign pending = st_q & mask_q;

  for (genvar h = 0; h < NHALVES; h++) begin : g_half
    assign half_req[h] = |pending[h*HALF +: HALF];
  end

  assign irq_lo = half_req[0];
  assign irq_hi = half_req[NHALVES-1];
endmodule

// File: rtl/pin_bank_irq_chk.sv
`timescale 1ns/1ps
module pin_bank_irq_chk
  import pin_bank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic [WORD_W-1:0] reg_word,
  input logic [PINS-1:0]   reg_wdata,
  input logic [PINS-1:0]   pad_oe,
  input logic              irq_lo,
  input logic              irq_hi,
  input logic [PINS-1:0]   st_q,
  input logic [PINS-1:0]   mask_q,
  input logic [PINS-1:0]   trig_hit,
  input logic [PINS-1:0]   clr_mask
);
  // R3: a direction write shows on the output enables next cycle
  a_r3_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && reg_word == IDX_DIR) |=> (pad_oe == $past(reg_wdata)));

  // R6: cleared bits without a concurrent trigger are gone next cycle
  a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(clr_mask & ~trig_hit)) == '0));

  // R6: uncleared status bits stay set
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(st_q & ~clr_mask)) == $past(st_q & ~clr_mask)));

  // R8: a trigger always lands in status, even against a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(trig_hit)) == $past(trig_hit)));

  // R9: no mask, no request
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (!irq_lo && !irq_hi));

  // R9: upper request needs an enabled upper pin
  a_r9_hi_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (|mask_q[PINS-1:HALF]));
endmodule

bind pin_bank_irq pin_bank_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_word(reg_word), .reg_wdata(reg_wdata), .pad_oe(pad_oe),
  .irq_lo(irq_lo), .irq_hi(irq_hi), .st_q(st_q), .mask_q(mask_q),
  .trig_hit(trig_hit), .clr_mask(clr_mask)
);

// File: tb/pin_bank_irq_bench.sv
`timescale 1ns/1ps
module pin_bank_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_word = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        irq_lo;
  logic        irq_hi;
  logic [31:0] ext = '0;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  pin_bank_irq u_pin_bank_irq (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_word(reg_word), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_word = w; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 0; reg_word = w;
    #1 d = reg_rdata;
    reg_sel = 0;
  endtask

  // Predicted status after: settle on old, clear all, then settle on new.
  function automatic logic [31:0] predict(input logic [31:0] cl, input logic [31:0] ch,
                                          input logic [31:0] o, input logic [31:0] n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] c;
      c = (i < 16) ? cl[2*i +: 2] : ch[2*(i-16) +: 2];
      case (c)
        2'd0: r[i] = !(o[i] && n[i]);
        2'd1: r[i] = o[i] || n[i];
        2'd2: r[i] = !o[i] && n[i];
        default: r[i] = o[i] && !n[i];
      endcase
    end
    return r;
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] v, d, dir, cl, ch, o, n, m, exp;
    void'($urandom(32'd20240607));
    cycles(3);
    rst_n = 1;
    cycles(1);

    // R1 reset state
    rd(3'd0, v); check("R1 data", v, 0);
    rd(3'd1, v); check("R1 dir", v, 0);
    rd(3'd3, v); check("R1 cfg_lo", v, 0);
    rd(3'd4, v); check("R1 cfg_hi", v, 0);
    rd(3'd5, v); check("R1 mask", v, 0);
    check("R1 oe", pad_oe, 0);
    check("R1 irq", {30'd0, irq_hi, irq_lo}, 0);

    // R2 read back and unmapped
    for (int k = 0; k < 4; k++) begin
      for (int w = 0; w < 6; w++) begin
        if (w == 2) continue;
        d = $urandom;
        wr(w[2:0], d);
        rd(w[2:0], v); check("R2 readback", v, d);
      end
    end
    wr(3'd0, 32'h1234_5678);
    wr(3'd7, 32'hFFFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd7, v); check("R2 unmapped read", v, 0);
    rd(3'd0, v); check("R2 ignored writes", v, 32'h1234_5678);

    // R3 / R4 direction and pad readback
    for (int k = 0; k < 8; k++) begin
      d = $urandom; dir = $urandom; ext = $urandom;
      wr(3'd0, d); wr(3'd1, dir);
      check("R3 oe", pad_oe, dir);
      check("R3 out", pad_out, d);
      cycles(3);
      rd(3'd2, v); check("R4 pad level", v, (dir & d) | (~dir & ext));
    end

    wr(3'd1, 0); wr(3'd0, 0); wr(3'd5, 0);

    // R5 / R9 random trigger configurations
    for (int k = 0; k < 16; k++) begin
      cl = $urandom; ch = $urandom; o = $urandom; n = $urandom;
      wr(3'd5, 0); wr(3'd3, cl); wr(3'd4, ch);
      ext = o; cycles(4);
      wr(3'd6, 32'hFFFF_FFFF);
      ext = n; cycles(4);
      exp = predict(cl, ch, o, n);
      rd(3'd6, v); check("R5 status", v, exp);
      m = $urandom;
      if (k % 4 == 0) m = m & 32'h0000_FFFF;
      wr(3'd5, m);
      check("R9 irq_lo", {31'd0, irq_lo}, {31'd0, |(exp[15:0] & m[15:0])});
      check("R9 irq_hi", {31'd0, irq_hi}, {31'd0, |(exp[31:16] & m[31:16])});
    end

    // R10 edge latency on pin 0 (rising), others low-level but masked
    wr(3'd5, 0); ext = 0; wr(3'd3, 32'h2); wr(3'd4, 0); cycles(4);
    wr(3'd6, 32'hFFFF_FFFF); wr(3'd5, 32'h1);
    check("R10 idle", {31'd0, irq_lo}, 0);
    ext[0] = 1'b1;
    cycles(2);
    check("R10 not yet after two edges", {31'd0, irq_lo}, 0);
    cycles(1);
    check("R10 set at third edge", {31'd0, irq_lo}, 1);
    ext[0] = 1'b0; cycles(4);
    rd(3'd6, v); check("R6 edge sticky", v & 32'h1, 32'h1);
    wr(3'd6, 32'h0);
    rd(3'd6, v); check("R6 write zero keeps", v & 32'h1, 32'h1);
    wr(3'd6, 32'h1);
    rd(3'd6, v); check("R6 write one clears", v & 32'h1, 32'h0);
    check("R6 irq drops", {31'd0, irq_lo}, 0);

    // R8 clear in the same cycle the edge sets the bit
    @(negedge clk); ext[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_word = 3'd6; reg_wdata = 32'h1;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0;
    rd(3'd6, v); check("R8 set wins", v & 32'h1, 32'h1);
    wr(3'd6, 32'h1);
    rd(3'd6, v); check("R8 later clear works", v & 32'h1, 32'h0);

    // R7 high level on pin 16
    wr(3'd4, 32'h1); wr(3'd5, 32'h0001_0000);
    ext[16] = 1'b1; cycles(4);
    check("R7 irq_hi raised", {31'd0, irq_hi}, 1);
    wr(3'd6, 32'h0001_0000);
    rd(3'd6, v); check("R7 level re-sets", v & 32'h0001_0000, 32'h0001_0000);
    check("R7 irq_hi held", {31'd0, irq_hi}, 1);
    ext[16] = 1'b0; cycles(4);
    wr(3'd6, 32'h0001_0000);
    rd(3'd6, v); check("R7 clears once level gone", v & 32'h0001_0000, 0);
    check("R9 irq_hi low", {31'd0, irq_hi}, 0);

    finish_up();
  end
endmodule